// File: doc/BRIEF.md
# Zero-Data Automute Detector

This block watches a stream of received audio frames and raises a mute flag when the stream has carried nothing but digital silence for a long, programmable stretch. The default is 24000 frames, which is half a second at a 48 kHz frame rate. Each frame carries one signed sample word per channel. A frame counts as silent only when every channel's word is exactly zero. The first frame with any nonzero bit on any channel ends the silent run. The mute flag then drops on the next clock edge, and the run count starts again from zero.

Two control inputs with opposite senses gate the detector. The first is an automute enable taken from the control register, and it is active low: 0 lets the detector run and 1 stops it. The second is a disable bit taken from the test register, where a 1 stops the detector. Both inputs reset to 0, so detection is active straight after reset. While either input stops the detector, the mute flag is held low and the silent-run count is held at zero.

Frames arrive on a valid/ready interface. The detector reads every frame in the cycle it is offered and never applies back-pressure, so ready is tied high. A cycle without valid neither advances nor clears the run count, whatever the data lines carry. The block only produces the flag. Attenuating the audio is left to the downstream path.

Top module: `automute_detect`

## Requirements
- R1: After reset `mute` is 0 and `in_ready` is 1.
- R2: With `cfg_amute_n`=0 and `tst_disable`=0, `mute` becomes 1 in the cycle after the THRESH-th consecutive accepted frame whose channel words are all zero. It stays 0 after only THRESH-1 such frames.
- R3: An accepted frame with any nonzero bit in any channel word sets `mute` to 0 in the next cycle. It also restarts the run, so THRESH further all-zero frames are needed before `mute` is 1 again.
- R4: A cycle with `in_valid`=0 leaves the run count and `mute` unchanged, even when `in_data` is nonzero.
- R5: The run count saturates at THRESH and does not wrap. Once `mute` is 1, further all-zero frames keep it at 1 for any number of frames.
- R6: While `cfg_amute_n`=1, `mute` is 0 from the next cycle and the run count is held at zero. After the input returns to 0, THRESH fresh all-zero frames are needed before `mute` is 1.
- R7: While `tst_disable`=1, the block behaves as in R6: `mute` is 0 from the next cycle and the run count is held at zero.
- R8: `in_ready` is 1 in every cycle after reset, so every frame offered with `in_valid`=1 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A frame is offered on `in_data` |
| in_ready | output | 1 | Always 1. The detector accepts every offered frame |
| in_data | input | NCH*W | Channel words of one frame, channel 0 in the low W bits |
| cfg_amute_n | input | 1 | Automute enable, active low (0 = detect, 1 = off) |
| tst_disable | input | 1 | Test disable bit (1 = detection off) |
| mute | output | 1 | 1 while a silent run of THRESH or more frames is in progress |

## Verification
The assertions are evaluated on every clock. They check the following rules: a nonzero accepted frame clears `mute` in the next cycle, and either control input does the same. A cycle without a frame leaves `mute` as it was. `mute` can only rise after an accepted all-zero frame while detection is on, and once high it holds under further silence. Ready never drops. Only the bench's scenarios can show the exact frame count at which `mute` rises, that an idle gap carrying nonzero data does not break a silent run, that a run interrupted by one nonzero word must start over from zero, and that leaving a disabled state demands a full fresh run.

// File: rtl/automute_pkg.sv
package automute_pkg;

  typedef struct packed {
    logic amute_n;   // control-register enable, active low
    logic test_off;  // test-register disable, active high
  } am_ctrl_t;

  function automatic logic am_detect_on(input am_ctrl_t c);
    return (c.amute_n == 1'b0) && (c.test_off == 1'b0);
  endfunction

endpackage

// File: rtl/am_frame_zero.sv
module am_frame_zero #(
  parameter int unsigned NCH = 6,
  parameter int unsigned W   = 24
) (
  input  logic [NCH*W-1:0] frame,
  output logic             all_zero
);
  logic [NCH-1:0] ch_zero;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_zero[g] = (frame[g*W +: W] == '0);
  end

  assign all_zero = &ch_zero;
endmodule

// File: rtl/am_enable_gate.sv
module am_enable_gate
  import automute_pkg::*;
(
  input  logic cfg_amute_n,
  input  logic tst_disable,
  output logic detect_on
);
  am_ctrl_t ctrl;

  always_comb begin
    ctrl.amute_n  = cfg_amute_n;
    ctrl.test_off = tst_disable;
    detect_on     = am_detect_on(ctrl);
  end
endmodule

// File: rtl/am_run_counter.sv
module am_run_counter #(
  parameter int unsigned THRESH = 24000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic step,
  input  logic silent,
  output logic full
);
  localparam int unsigned CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] LIMIT = CW'(THRESH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!enable) begin
      cnt_d = '0;
    end else if (step) begin
      if (!silent)           cnt_d = '0;
      else if (cnt_q < LIMIT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= (cnt_d == LIMIT);
    end
  end

  assign full = full_q;
endmodule

// File: rtl/automute_detect.sv
module automute_detect #(
  parameter int unsigned NCH    = 6,
  parameter int unsigned W      = 24,
  parameter int unsigned THRESH = 24000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NCH*W-1:0] in_data,
  input  logic             cfg_amute_n,
  input  logic             tst_disable,
  output logic             mute
);
  logic all_zero;
  logic detect_on;
  logic take;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  am_frame_zero #(.NCH(NCH), .W(W)) u_zero (
    .frame    (in_data),
    .all_zero (all_zero)
  );

  am_enable_gate u_gate (
    .cfg_amute_n (cfg_amute_n),
    .tst_disable (tst_disable),
    .detect_on   (detect_on)
  );

  am_run_counter #(.THRESH(THRESH)) u_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (detect_on),
    .step   (take),
    .silent (all_zero),
    .full   (mute)
  );
endmodule

// File: rtl/automute_detect_chk.sv
module automute_detect_chk #(
  parameter int unsigned NCH = 6,
  parameter int unsigned W   = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [NCH*W-1:0] in_data,
  input logic             cfg_amute_n,
  input logic             tst_disable,
  input logic             mute
);
  logic on;
  assign on = !cfg_amute_n && !tst_disable;

  // R3
  nonzero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data != '0) |=> !mute);

  // R6
  amute_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_amute_n |=> !mute);

  // R7
  test_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tst_disable |=> !mute);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && on) |=> $stable(mute));

  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute) |-> $past(in_valid && in_data == '0 && on));

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute && in_valid && in_data == '0 && on) |=> mute);

  // R8
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

bind automute_detect automute_detect_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_data     (in_data),
  .cfg_amute_n (cfg_amute_n),
  .tst_disable (tst_disable),
  .mute        (mute)
);

// File: tb/tb_automute_detect.sv
module tb_automute_detect;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int W = 24;
  localparam int TH = 10;
  localparam int DW = NCH * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic cfg_amute_n = 1'b0;
  logic tst_disable = 1'b0;
  logic mute;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  automute_detect #(.NCH(NCH), .W(W), .THRESH(TH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_amute_n(cfg_amute_n), .tst_disable(tst_disable),
    .mute(mute)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected mute after the edge goes to the scoreboard
  task automatic send(input logic v, input logic [DW-1:0] d, input logic exp, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    @(posedge clk);
    #1;
    e.exp = exp;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic zeros(input int n, input logic exp_last, input string tag);
    for (int i = 1; i <= n; i++)
      send(1'b1, '0, (i == n) ? exp_last : 1'b0, tag);
  endtask

  // monitor: compare mute with the scoreboard, away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(mute, e.exp, e.tag);
    end
  end

  logic [DW-1:0] one_ch2;
  logic [DW-1:0] neg_ch0;
  logic [DW-1:0] junk;

  initial begin
    one_ch2 = '0; one_ch2[2*W] = 1'b1;
    neg_ch0 = '0; neg_ch0[W-1:0] = {W{1'b1}};
    junk = {NCH{24'h5A5A5A}};

    #(CLK_PERIOD*3 + 2);
    chk(mute, 1'b0, "R1 mute in reset");
    chk(in_ready, 1'b1, "R1 ready in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(mute, 1'b0, "R1 mute after reset");
    chk(in_ready, 1'b1, "R8 ready after reset");

    // R2: THRESH-1 frames leave mute low, the THRESH-th sets it
    zeros(TH - 1, 1'b0, "R2 below threshold");
    send(1'b1, '0, 1'b1, "R2 threshold reached");

    // R5: saturation, no wrap
    for (int i = 0; i < 3*TH; i++) send(1'b1, '0, 1'b1, "R5 saturated");

    // R3: one nonzero bit in channel 2 clears and restarts
    send(1'b1, one_ch2, 1'b0, "R3 nonzero ch2");
    zeros(TH - 1, 1'b0, "R3 restart below");
    send(1'b1, '0, 1'b1, "R3 restart reached");
    send(1'b1, neg_ch0, 1'b0, "R3 negative ch0");
    zeros(TH, 1'b1, "R3 second restart");

    // R4: idle gap with nonzero data does not touch the run
    send(1'b1, neg_ch0, 1'b0, "R4 clear");
    zeros(5, 1'b0, "R4 before gap");
    for (int i = 0; i < 3*TH; i++) send(1'b0, junk, 1'b0, "R4 idle gap");
    zeros(4, 1'b0, "R4 after gap");
    send(1'b1, '0, 1'b1, "R4 run continues");
    for (int i = 0; i < 5; i++) send(1'b0, junk, 1'b1, "R4 idle keeps mute");

    // R6: active-low enable set to 1 forces low, even without a frame
    cfg_amute_n = 1'b1;
    send(1'b0, '0, 1'b0, "R6 drop on idle");
    for (int i = 0; i < 2*TH; i++) send(1'b1, '0, 1'b0, "R6 held off");
    cfg_amute_n = 1'b0;
    zeros(TH - 1, 1'b0, "R6 fresh run below");
    send(1'b1, '0, 1'b1, "R6 fresh run reached");

    // R7: test disable bit
    tst_disable = 1'b1;
    send(1'b1, '0, 1'b0, "R7 drop");
    for (int i = 0; i < 2*TH; i++) send(1'b1, '0, 1'b0, "R7 held off");
    tst_disable = 1'b0;
    zeros(TH - 1, 1'b0, "R7 fresh run below");
    send(1'b1, '0, 1'b1, "R7 fresh run reached");

    // R6/R7: both set together
    cfg_amute_n = 1'b1; tst_disable = 1'b1;
    zeros(3, 1'b0, "R7 both off");
    cfg_amute_n = 1'b0; tst_disable = 1'b0;
    chk(in_ready, 1'b1, "R8 ready at end");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule